// File: doc/BRIEF.md
# Packed-Half Vector Load/Store Unit

This unit moves one 128-bit vector register, seen as eight 16-bit elements, to or from a byte-addressed memory in packed-half form. Each memory byte stands for bits 14..7 of one element. A load reads eight bytes spaced two apart and widens each byte into its element, with every other bit cleared. A store takes two adjacent register bytes at a time, joins them into one byte that straddles the byte boundary, and writes eight such bytes spaced two apart. The memory offset of each transfer wraps inside a 16-byte window that sits on an 8-byte-aligned base.

A command carries a base address, a 7-bit signed offset, a starting byte-lane index and, for stores, the register contents. The command port uses valid/ready. `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The source must hold the command stable until that edge, and the unit ignores the command port while it is busy. The memory port is plain: one byte per cycle, and read data is expected in the same cycle as the request. `done` is a one-cycle status pulse. Instruction decode and the register file are outside the unit.

Top module: `vhp_lsu`

## Requirements
- R1: `cmd_ready` is high exactly when no transfer is in progress. A command is taken on an edge with `cmd_valid` and `cmd_ready` both high. While a transfer is in progress, `cmd_ready` is low and changes on the command inputs have no effect on the running transfer.
- R2: The effective address is `cmd_base` plus `cmd_offset`, sign-extended and multiplied by 16. The inner offset is its low three bits. The aligned base is the effective address with those three bits cleared.
- R3: A taken command produces exactly eight memory accesses, with `mem_req` high, in the eight cycles right after the accepting edge. `mem_req` is low at all other times.
- R4: For a load, access i (0..7) reads address aligned + ((16 − elem + 2i + inner) mod 16), with `mem_we` low.
- R5: On a load, element i of the result is {1'b0, byte read in access i, 7'b0}. Element 0 sits in bits 127:112 and element 7 in bits 15:0.
- R6: Register byte lane k is bits [127−8k −: 8], so the lanes are big-endian within each element. For a store, access i writes the low 8 bits of (b0 << 1) | (b1 >> 7). Here b0 is lane (elem + 2i) mod 16 and b1 is lane (elem + 2i + 1) mod 16.
- R7: For a store, access i writes address aligned + ((inner + 2i) mod 16), with `mem_we` high.
- R8: `done` is high for exactly one cycle, the cycle after the eighth access. After a load, `vreg_out` shows the new result in that cycle and keeps it until the next load's `done`. A store never changes `vreg_out`.
- R9: A new command can be taken on the edge that ends the `done` cycle, with no idle cycle in between.
- R10: During and right after reset, `cmd_ready` is high, while `done`, `mem_req` and `vreg_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | 32 | Base address |
| cmd_offset | input | 7 | Signed offset in 16-byte units |
| cmd_elem | input | 4 | Starting byte lane |
| cmd_vreg | input | 128 | Register contents for a store |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the request cycle |
| done | output | 1 | Transfer complete pulse |
| vreg_out | output | 128 | Last load result |

## Verification
Two things can land in the same cycle: the `done` pulse that finishes one transfer, and the acceptance of the next command. The bench provokes this by offering each new command in the `done` cycle of the one before it. It then checks that `cmd_ready` is high there and that the first access follows at once. It also checks that `vreg_out` still holds the earlier load result while the new transfer runs. During some transfers the bench keeps `cmd_valid` high with altered fields, and it judges each access address and write byte against values it computed from the original command.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Join two register bytes into one byte straddling their boundary.
  function automatic logic [7:0] pack_pair(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[6:0], lo[7]};
  endfunction

  // Widen one memory byte into element bits 14..7.
  function automatic logic [15:0] unpack_byte(input logic [7:0] b);
    return {1'b0, b, 7'b0};
  endfunction

endpackage

// File: rtl/vhp_ea_calc.sv
module vhp_ea_calc #(
  parameter int AW     = 32,
  parameter int OFFW   = 7,
  parameter int SCL_SH = 4,
  parameter int IW     = 3
) (
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] offset,
  output logic [AW-1:0]   aligned,
  output logic [IW-1:0]   inner
);
  logic [AW-1:0] off_x;
  logic [AW-1:0] ea;

  assign off_x   = AW'($signed(offset));
  assign ea      = base + (off_x << SCL_SH);
  assign inner   = ea[IW-1:0];
  assign aligned = {ea[AW-1:IW], {IW{1'b0}}};
endmodule

// File: rtl/vhp_step_addr.sv
module vhp_step_addr #(
  parameter int AW    = 32,
  parameter int LANES = 16,
  parameter int IW    = 3,
  localparam int LW   = $clog2(LANES),
  localparam int SW   = $clog2(LANES / 2)
) (
  input  logic [AW-1:0] aligned,
  input  logic [IW-1:0] inner,
  input  logic [LW-1:0] elem,
  input  logic [SW-1:0] step,
  input  logic          is_store,
  output logic [AW-1:0] addr
);
  logic [LW-1:0] win;
  logic [LW-1:0] bias;

  // Loads start (LANES - elem) into the window; LW-bit wrap gives the mod.
  assign bias = is_store ? '0 : (LW'(0) - elem);
  assign win  = LW'(inner) + LW'({step, 1'b0}) + bias;
  assign addr = aligned + AW'(win);
endmodule

// File: rtl/vhp_store_pack.sv
module vhp_store_pack
  import vhp_pkg::*;
#(
  parameter int LANES = 16,
  localparam int LW   = $clog2(LANES),
  localparam int SW   = $clog2(LANES / 2),
  localparam int DW   = 8 * LANES
) (
  input  logic [DW-1:0] vreg,
  input  logic [LW-1:0] elem,
  input  logic [SW-1:0] step,
  output logic [7:0]    wbyte
);
  logic [7:0]    lane [LANES];
  logic [LW-1:0] j0;
  logic [LW-1:0] j1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = vreg[DW-1-8*k -: 8];
  end

  assign j0    = elem + LW'({step, 1'b0});
  assign j1    = j0 + LW'(1);
  assign wbyte = pack_pair(lane[j0], lane[j1]);
endmodule

// File: rtl/vhp_load_place.sv
module vhp_load_place
  import vhp_pkg::*;
#(
  parameter int LANES = 16,
  localparam int ELEMS = LANES / 2,
  localparam int SW    = $clog2(ELEMS),
  localparam int DW    = 8 * LANES
) (
  input  logic [DW-1:0] cur,
  input  logic [7:0]    rbyte,
  input  logic [SW-1:0] step,
  input  logic          en,
  output logic [DW-1:0] nxt
);
  for (genvar g = 0; g < ELEMS; g++) begin : g_elem
    assign nxt[DW-1-16*g -: 16] = (en && step == SW'(g)) ? unpack_byte(rbyte)
                                                         : cur[DW-1-16*g -: 16];
  end
endmodule

// File: rtl/vhp_lsu.sv
module vhp_lsu
  import vhp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int OFFW   = 7,
  parameter int LANES  = 16,
  parameter int SCL_SH = 4,
  parameter int IW     = 3,
  localparam int LW    = $clog2(LANES),
  localparam int ELEMS = LANES / 2,
  localparam int SW    = $clog2(ELEMS),
  localparam int DW    = 8 * LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_store,
  input  logic [AW-1:0]   cmd_base,
  input  logic [OFFW-1:0] cmd_offset,
  input  logic [LW-1:0]   cmd_elem,
  input  logic [DW-1:0]   cmd_vreg,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            done,
  output logic [DW-1:0]   vreg_out
);
  phase_t        phase_q;
  logic [SW-1:0] step_q;
  logic          store_q;
  logic [LW-1:0] elem_q;
  logic [IW-1:0] inner_q;
  logic [AW-1:0] aligned_q;
  logic [DW-1:0] work_q;
  logic [DW-1:0] work_nxt;
  logic [DW-1:0] vout_q;
  logic          done_q;

  logic [AW-1:0] aligned_c;
  logic [IW-1:0] inner_c;
  logic          run;
  logic          last;
  logic          accept;

  assign run       = (phase_q == PH_RUN);
  assign last      = (step_q == SW'(ELEMS - 1));
  assign cmd_ready = !run;
  assign accept    = cmd_valid && cmd_ready;

  vhp_ea_calc #(.AW(AW), .OFFW(OFFW), .SCL_SH(SCL_SH), .IW(IW)) u_ea (
    .base    (cmd_base),
    .offset  (cmd_offset),
    .aligned (aligned_c),
    .inner   (inner_c)
  );

  vhp_step_addr #(.AW(AW), .LANES(LANES), .IW(IW)) u_addr (
    .aligned  (aligned_q),
    .inner    (inner_q),
    .elem     (elem_q),
    .step     (step_q),
    .is_store (store_q),
    .addr     (mem_addr)
  );

  vhp_store_pack #(.LANES(LANES)) u_pack (
    .vreg  (work_q),
    .elem  (elem_q),
    .step  (step_q),
    .wbyte (mem_wdata)
  );

  vhp_load_place #(.LANES(LANES)) u_place (
    .cur   (work_q),
    .rbyte (mem_rdata),
    .step  (step_q),
    .en    (run && !store_q),
    .nxt   (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      step_q    <= '0;
      store_q   <= 1'b0;
      elem_q    <= '0;
      inner_q   <= '0;
      aligned_q <= '0;
      work_q    <= '0;
      vout_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        phase_q   <= PH_RUN;
        step_q    <= '0;
        store_q   <= cmd_store;
        elem_q    <= cmd_elem;
        inner_q   <= inner_c;
        aligned_q <= aligned_c;
        work_q    <= cmd_vreg;
      end else if (run) begin
        step_q <= step_q + SW'(1);
        work_q <= work_nxt;
        if (last) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
          if (!store_q) vout_q <= work_nxt;
        end
      end
    end
  end

  assign mem_req  = run;
  assign mem_we   = run && store_q;
  assign done     = done_q;
  assign vreg_out = vout_q;

  // R3
  accept_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> mem_req);

  // R8
  last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && last) |=> (done && cmd_ready));

  // R4
  stride_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !last) |=> (mem_req && ((mem_addr == $past(mem_addr) + AW'(2)) ||
                                        (mem_addr == $past(mem_addr) - AW'(LANES - 2)))));

  // R7
  dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !last) |=> (mem_we == $past(mem_we)));

  // R8
  store_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && store_q) |-> $stable(vreg_out));

  // R5
  for (genvar g = 0; g < ELEMS; g++) begin : g_pad_chk
    elem_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vreg_out[DW-1-16*g] == 1'b0) && (vreg_out[DW-16*g-10 -: 7] == 7'd0));
  end
endmodule

// File: tb/vhp_lsu_tb.sv
`timescale 1ns/1ps
module vhp_lsu_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic         cmd_ready;
  logic         cmd_store;
  logic [31:0]  cmd_base;
  logic [6:0]   cmd_offset;
  logic [3:0]   cmd_elem;
  logic [127:0] cmd_vreg;
  logic         mem_req;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata;
  logic         done;
  logic [127:0] vreg_out;

  logic [7:0]   tb_mem [1024];
  logic [127:0] last_load;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = tb_mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_req && mem_we) tb_mem[mem_addr[9:0]] <= mem_wdata;

  vhp_lsu u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_elem(cmd_elem), .cmd_vreg(cmd_vreg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .vreg_out(vreg_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sbyte(input logic [127:0] v, input int e, input int i);
    int j0 = (e + 2 * i) % 16;
    int j1 = (e + 2 * i + 1) % 16;
    logic [7:0]  b0 = v[127 - 8 * j0 -: 8];
    logic [7:0]  b1 = v[127 - 8 * j1 -: 8];
    logic [15:0] t  = ({8'd0, b0} << 1) | ({8'd0, b1} >> 7);
    return t[7:0];
  endfunction

  // Caller is at a negedge; returns at the negedge of the done cycle.
  task automatic run_op(input bit st, input logic [31:0] base, input logic [6:0] off,
                        input logic [3:0] e, input logic [127:0] v, input bit noisy);
    logic [31:0]  ea = base + ({{25{off[6]}}, off} << 4);
    logic [31:0]  al = {ea[31:3], 3'b0};
    int           inr = int'(ea[2:0]);
    logic [127:0] exp_res = '0;
    logic [31:0]  a;
    check(cmd_ready == 1'b1, done ? "R9" : "R1", "ready at offer", 128'(cmd_ready), 128'(1));
    cmd_valid = 1'b1; cmd_store = st; cmd_base = base; cmd_offset = off;
    cmd_elem = e; cmd_vreg = v;
    @(negedge clk);
    if (noisy) begin
      cmd_base = $urandom; cmd_elem = 4'($urandom); cmd_vreg = {4{$urandom}};
      cmd_store = ~st; cmd_offset = 7'($urandom);
    end else cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (st) begin
        a = al + 32'((inr + 2 * i) & 15);
        check(mem_req && mem_we, "R7", "store access", {mem_req, mem_we}, 2'b11);
        check(mem_addr == a, "R7", "store addr", mem_addr, a);
        check(mem_wdata == exp_sbyte(v, int'(e), i), "R6", "store byte",
              mem_wdata, exp_sbyte(v, int'(e), i));
      end else begin
        a = al + 32'((16 - int'(e) + 2 * i + inr) & 15);
        check(mem_req && !mem_we, "R4", "load access", {mem_req, mem_we}, 2'b10);
        check(mem_addr == a, "R4", "load addr", mem_addr, a);
        exp_res[127 - 16 * i -: 16] = {1'b0, tb_mem[a[9:0]], 7'b0};
      end
      check(cmd_ready == 1'b0, "R1", "ready while busy", 128'(cmd_ready), 0);
      check(done == 1'b0, "R8", "done early", 128'(done), 0);
      if (i == 0) check(vreg_out == last_load, "R8", "out held during op", vreg_out, last_load);
      if (i == 7) cmd_valid = 1'b0;
      @(negedge clk);
    end
    check(done == 1'b1 && mem_req == 1'b0, "R3", "done, no ninth access",
          {done, mem_req}, 2'b10);
    if (!st) begin
      check(vreg_out == exp_res, "R5", "load result", vreg_out, exp_res);
      last_load = exp_res;
    end else begin
      check(vreg_out == last_load, "R8", "store leaves out", vreg_out, last_load);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 1024; k++) tb_mem[k] = 8'($urandom);
    last_load = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_base = '0;
    cmd_offset = '0; cmd_elem = '0; cmd_vreg = '0;
    repeat (3) @(negedge clk);
    check(cmd_ready && !done && !mem_req && vreg_out == '0, "R10", "in reset",
          {cmd_ready, done, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !done && !mem_req && vreg_out == '0, "R10", "after reset",
          {cmd_ready, done, mem_req}, 3'b100);

    // R2/R4/R5 directed loads: aligned, inner offset, negative offset with lane 15
    run_op(1'b0, 32'h200, 7'd0,    4'd0,  '0, 1'b0);
    run_op(1'b0, 32'h203, 7'd1,    4'd5,  '0, 1'b0);
    run_op(1'b0, 32'h1FF, 7'h7F,   4'd15, '0, 1'b1);
    // R6/R7 directed stores, R9 chained from the previous done
    run_op(1'b1, 32'h200, 7'd0,    4'd0,  128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0);
    run_op(1'b1, 32'h107, 7'd2,    4'd15, 128'h80FF017F_00C03E81_AA55F00F_7E01FF80, 1'b1);
    run_op(1'b1, 32'h2FE, 7'h7C,   4'd1,  {16{8'h80}}, 1'b0);
    // read back stored bytes through a load at matching geometry
    run_op(1'b0, 32'h200, 7'd0,    4'd0,  '0, 1'b0);
    @(negedge clk);
    check(done == 1'b0 && mem_req == 1'b0, "R8", "done one cycle", {done, mem_req}, 2'b00);

    for (int n = 0; n < 60; n++) begin
      bit st = 1'($urandom);
      logic [31:0] b = 32'h200 + 32'($urandom % 512);
      int so = int'($urandom % 9) - 4;
      run_op(st, b, 7'(so), 4'($urandom), {$urandom, $urandom, $urandom, $urandom},
             1'($urandom));
      if ((n % 7) == 3) @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule